// File: doc/BRIEF.md
# Cache line flush and writeback unit

This block holds a small direct-mapped write-back data cache and carries out cache-maintenance commands against it. A command enters on a valid/ready port with a two-bit opcode and a line address. There are four kinds of command. A serialising flush waits for full quiescence and holds the port until its own write is acknowledged. An unordered flush can overlap earlier writes. A writeback-only operation leaves the line resident but clean. A fence drains every outstanding write and then signals completion.

When a line is dirty, its data leaves on a memory write port. This port issues one-cycle write pulses, and memory acknowledges them in issue order. A counter tracks writes that are still waiting on memory, up to a fixed depth. A preload and peek side port lets a line be seeded and inspected.

Top module: `pmem_flush_unit`

## Requirements
- R1: A synchronous active-high reset leaves every line invalid and clean, empties the outstanding count, and raises cmd_ready. fence_done and mem_wr_valid are low after reset.
- R2: A serialising flush (opcode 0) is accepted only when no write is outstanding. After it is accepted, cmd_ready stays low for at least one cycle, and it stays low until its own write has been acknowledged.
- R3: Unordered flushes (opcode 1) and writebacks (opcode 2) are accepted while earlier writes are still unacknowledged.
- R4: A flush of either kind that hits a dirty line issues one memory write in the cycle after acceptance. mem_wr_addr carries the request's line address and mem_wr_data carries the line data. The line is then invalid.
- R5: A writeback (opcode 2) that hits a dirty line issues the same write. The line then stays valid with its dirty bit cleared.
- R6: A request that misses produces no write and changes no line. A request that hits a clean line also produces no write, but a flush of a clean hit still invalidates the line. The line address is {tag, index}, with the index in the low bits.
- R7: At most QDEPTH writes are outstanding. While QDEPTH writes are outstanding, cmd_ready is low.
- R8: Each mem_wr_ack retires the oldest outstanding write. An acknowledge that arrives while nothing is outstanding is ignored.
- R9: After a fence (opcode 3) is accepted, cmd_ready is low until all earlier writes are acknowledged. fence_done then pulses for one cycle. If nothing is outstanding, the pulse comes in the cycle after acceptance.
- R10: When pl_en is high, the line at pl_idx is written with pl_tag, pl_data, pl_valid and pl_dirty. The pk_* outputs show the state of line pk_idx combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command valid |
| cmd_ready | output | 1 | Command may be accepted |
| cmd_op | input | 2 | 0 serial flush, 1 unordered flush, 2 writeback, 3 fence |
| cmd_addr | input | ADDR_W | Line address {tag, index} |
| mem_wr_valid | output | 1 | One-cycle memory write pulse |
| mem_wr_addr | output | ADDR_W | Line address written |
| mem_wr_data | output | DATA_W | Line data written |
| mem_wr_ack | input | 1 | Acknowledge of oldest outstanding write |
| fence_done | output | 1 | Fence completion pulse |
| pl_en | input | 1 | Preload strobe |
| pl_idx | input | IDX_W | Preload line index |
| pl_tag | input | TAG_W | Preload tag |
| pl_data | input | DATA_W | Preload data |
| pl_valid | input | 1 | Preload valid bit |
| pl_dirty | input | 1 | Preload dirty bit |
| pk_idx | input | IDX_W | Peek line index |
| pk_valid | output | 1 | Peeked valid bit |
| pk_dirty | output | 1 | Peeked dirty bit |
| pk_tag | output | TAG_W | Peeked tag |
| pk_data | output | DATA_W | Peeked data |

## Verification
The bench uses the default parameters: eight lines, 8-bit line addresses (a 3-bit index and a 5-bit tag), 32-bit data and a write queue depth of four. The queue is shallow, so a burst of five unordered flushes with a slow acknowledge fills it and exposes the full stall. The small line count lets every line be seeded with a distinct tag and dirty state, so tag-mismatch misses, clean hits and dirty hits all occur within one short run.

// File: rtl/pmem_flush_unit.sv
module pmem_flush_unit #(
  parameter int NLINES = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int QDEPTH = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cmd_valid,
  output logic                        cmd_ready,
  input  logic [1:0]                  cmd_op,
  input  logic [ADDR_W-1:0]           cmd_addr,
  output logic                        mem_wr_valid,
  output logic [ADDR_W-1:0]           mem_wr_addr,
  output logic [DATA_W-1:0]           mem_wr_data,
  input  logic                        mem_wr_ack,
  output logic                        fence_done,
  input  logic                        pl_en,
  input  logic [$clog2(NLINES)-1:0]   pl_idx,
  input  logic [ADDR_W-$clog2(NLINES)-1:0] pl_tag,
  input  logic [DATA_W-1:0]           pl_data,
  input  logic                        pl_valid,
  input  logic                        pl_dirty,
  input  logic [$clog2(NLINES)-1:0]   pk_idx,
  output logic                        pk_valid,
  output logic                        pk_dirty,
  output logic [ADDR_W-$clog2(NLINES)-1:0] pk_tag,
  output logic [DATA_W-1:0]           pk_data
);
  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam int CNT_W = $clog2(QDEPTH + 1);

  logic [NLINES-1:0] vld, drt;
  logic [TAG_W-1:0]  tags [NLINES];
  logic [DATA_W-1:0] lines [NLINES];
  logic [CNT_W-1:0]  outstanding;
  logic              fence_pend, ser_wait;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tg;
  logic              hit, acc, push, ack_ok, is_fence;

  assign idx      = cmd_addr[IDX_W-1:0];
  assign tg       = cmd_addr[ADDR_W-1:IDX_W];
  assign hit      = vld[idx] && (tags[idx] == tg);
  assign is_fence = (cmd_op == 2'd3);
  assign cmd_ready = !fence_pend && !ser_wait && (outstanding != CNT_W'(QDEPTH))
                     && ((cmd_op != 2'd0) || (outstanding == '0));
  assign acc      = cmd_valid && cmd_ready;
  assign push     = acc && !is_fence && hit && drt[idx];
  assign ack_ok   = mem_wr_ack && (outstanding != '0);
  assign fence_done = fence_pend && (outstanding == '0);

  assign pk_valid = vld[pk_idx];
  assign pk_dirty = drt[pk_idx];
  assign pk_tag   = tags[pk_idx];
  assign pk_data  = lines[pk_idx];

  always_ff @(posedge clk) begin
    if (rst) begin
      vld          <= '0;
      drt          <= '0;
      outstanding  <= '0;
      fence_pend   <= 1'b0;
      ser_wait     <= 1'b0;
      mem_wr_valid <= 1'b0;
      mem_wr_addr  <= '0;
      mem_wr_data  <= '0;
    end else begin
      outstanding  <= outstanding + CNT_W'(push) - CNT_W'(ack_ok);
      mem_wr_valid <= push;
      if (push) begin
        mem_wr_addr <= cmd_addr;
        mem_wr_data <= lines[idx];
      end
      if (fence_done)
        fence_pend <= 1'b0;
      else if (acc && is_fence)
        fence_pend <= 1'b1;
      if (acc && cmd_op == 2'd0)
        ser_wait <= 1'b1;
      else if (outstanding == '0)
        ser_wait <= 1'b0;
      if (acc && hit) begin
        if (cmd_op == 2'd0 || cmd_op == 2'd1) begin
          vld[idx] <= 1'b0;
          drt[idx] <= 1'b0;
        end else if (cmd_op == 2'd2) begin
          drt[idx] <= 1'b0;
        end
      end
      if (pl_en) begin
        vld[pl_idx] <= pl_valid;
        drt[pl_idx] <= pl_dirty;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (pl_en) begin
      tags[pl_idx]  <= pl_tag;
      lines[pl_idx] <= pl_data;
    end
  end
endmodule

// File: rtl/pmem_flush_unit_chk.sv
module pmem_flush_unit_chk #(
  parameter int CNT_W  = 3,
  parameter int QDEPTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             mem_wr_valid,
  input logic             fence_done,
  input logic [CNT_W-1:0] outstanding
);
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    outstanding <= CNT_W'(QDEPTH));
  p_full_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    (outstanding == CNT_W'(QDEPTH)) |-> !cmd_ready);
  p_serial_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd0) |-> (outstanding == '0));
  p_serial_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd0) |=> !cmd_ready);
  p_write_follows_accept_r4: assert property (@(posedge clk) disable iff (rst)
    mem_wr_valid |-> $past(cmd_valid && cmd_ready && cmd_op != 2'd3));
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    fence_done |=> !fence_done);
  p_done_drained_r9: assert property (@(posedge clk) disable iff (rst)
    fence_done |-> (outstanding == '0));
  p_fence_stalls_r9: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_op == 2'd3) |=> !cmd_ready);
endmodule

bind pmem_flush_unit pmem_flush_unit_chk #(.CNT_W(CNT_W), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_op(cmd_op), .mem_wr_valid(mem_wr_valid), .fence_done(fence_done),
  .outstanding(outstanding)
);

// File: tb/pmem_flush_unit_tb.sv
module pmem_flush_unit_tb;
  localparam int NL = 8, AW = 8, DW = 32, QD = 4, IW = 3, TW = 5;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic cmd_valid = 0, cmd_ready;
  logic [1:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0;
  logic mem_wr_valid, mem_wr_ack = 0, fence_done;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic pl_en = 0, pl_valid = 0, pl_dirty = 0;
  logic [IW-1:0] pl_idx = 0, pk_idx = 0;
  logic [TW-1:0] pl_tag = 0, pk_tag;
  logic [DW-1:0] pl_data = 0, pk_data;
  logic pk_valid, pk_dirty;

  pmem_flush_unit #(.NLINES(NL), .ADDR_W(AW), .DATA_W(DW), .QDEPTH(QD)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .mem_wr_valid(mem_wr_valid),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data), .mem_wr_ack(mem_wr_ack),
    .fence_done(fence_done), .pl_en(pl_en), .pl_idx(pl_idx), .pl_tag(pl_tag),
    .pl_data(pl_data), .pl_valid(pl_valid), .pl_dirty(pl_dirty), .pk_idx(pk_idx),
    .pk_valid(pk_valid), .pk_dirty(pk_dirty), .pk_tag(pk_tag), .pk_data(pk_data));

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference model
  bit mv[NL], md[NL];
  int mt[NL];
  logic [DW-1:0] mdat[NL];
  int mcnt = 0;
  bit mfp = 0, msw = 0, e_wv = 0;
  logic [AW-1:0] e_wa = 0;
  logic [DW-1:0] e_wd = 0;

  function automatic bit m_ready();
    return !mfp && !msw && mcnt < QD && (cmd_op != 0 || mcnt == 0);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NL; i++) begin mv[i] = 0; md[i] = 0; end
      mcnt = 0; mfp = 0; msw = 0; e_wv = 0;
    end else begin
      int ix, tg;
      bit acc, hit, push, ackok, done, was_zero;
      ix = cmd_addr % NL; tg = cmd_addr / NL;
      hit = mv[ix] && mt[ix] == tg;
      acc = cmd_valid && m_ready();
      push = acc && cmd_op != 3 && hit && md[ix];
      ackok = mem_wr_ack && mcnt > 0;
      done = mfp && mcnt == 0;
      was_zero = (mcnt == 0);
      e_wv = push;
      if (push) begin e_wa = cmd_addr; e_wd = mdat[ix]; end
      mcnt = mcnt + (push ? 1 : 0) - (ackok ? 1 : 0);
      if (done) mfp = 0; else if (acc && cmd_op == 3) mfp = 1;
      if (acc && cmd_op == 0) msw = 1; else if (was_zero) msw = 0;
      if (acc && hit) begin
        if (cmd_op <= 1) begin mv[ix] = 0; md[ix] = 0; end
        else if (cmd_op == 2) md[ix] = 0;
      end
      if (pl_en) begin
        mv[pl_idx] = pl_valid; md[pl_idx] = pl_dirty;
        mt[pl_idx] = pl_tag; mdat[pl_idx] = pl_data;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk("R2 R3 R7 R9 cmd_ready", cmd_ready, m_ready());
      chk("R9 fence_done", fence_done, mfp && mcnt == 0);
      chk("R4 R5 R6 R8 mem_wr_valid", mem_wr_valid, e_wv);
      if (e_wv) begin
        chk("R4 mem_wr_addr", mem_wr_addr, e_wa);
        chk("R4 mem_wr_data", mem_wr_data, e_wd);
      end
    end
  end

  // memory responder
  int issued = 0, acked = 0, ack_lat = 2, lat_cnt = 0;
  bit force_ack = 0;
  always @(negedge clk) if (!rst && mem_wr_valid) issued++;
  always @(posedge clk) begin
    #1;
    if (force_ack) begin
      mem_wr_ack = 1; force_ack = 0;
    end else if (issued > acked && lat_cnt >= ack_lat) begin
      mem_wr_ack = 1; acked++; lat_cnt = 0;
    end else begin
      mem_wr_ack = 0;
      if (issued > acked) lat_cnt++; else lat_cnt = 0;
    end
  end

  task automatic send(input logic [1:0] op, input int tag, input int ix);
    bit a;
    @(posedge clk); #1;
    cmd_valid = 1; cmd_op = op; cmd_addr = AW'(tag * NL + ix);
    do begin
      @(negedge clk); a = cmd_ready;
      @(posedge clk); #1;
    end while (!a);
    cmd_valid = 0;
  endtask

  task automatic preload(input int ix, input int tag, input logic [DW-1:0] d,
                         input bit v, input bit dy);
    @(posedge clk); #1;
    pl_en = 1; pl_idx = IW'(ix); pl_tag = TW'(tag); pl_data = d; pl_valid = v; pl_dirty = dy;
    @(posedge clk); #1;
    pl_en = 0;
  endtask

  task automatic fence_wait();
    int n;
    send(2'd3, 0, 0);
    n = 0;
    while (!fence_done && n < 1000) begin @(negedge clk); n++; end
    chk("R9 fence completes", fence_done, 1);
  endtask

  task automatic peek(input string req, input int ix, input bit v, input bit dy);
    pk_idx = IW'(ix); #0.1;
    chk(req, {pk_valid, pk_dirty}, {v, dy});
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    for (int i = 0; i < NL; i++) peek("R1 line cleared", i, 0, 0);
    chk("R1 ready after reset", cmd_ready, 1);
    chk("R1 no write after reset", mem_wr_valid, 0);
    for (int i = 0; i < NL; i++)
      preload(i, i + 1, 32'hA000_0000 + 32'(i * 17), 1, i != 2);
    @(negedge clk);
    peek("R10 preload visible", 3, 1, 1);
    pk_idx = 3; #0.1;
    chk("R10 preload tag", pk_tag, 4);
    chk("R10 preload data", pk_data, 32'hA000_0000 + 51);

    // writeback keeps line resident
    ack_lat = 2;
    send(2'd2, 1, 0);
    fence_wait();
    @(negedge clk);
    peek("R5 writeback leaves valid clean", 0, 1, 0);

    // overlapping unordered flushes, queue fills
    ack_lat = 8;
    send(2'd1, 2, 1);
    send(2'd1, 4, 3);
    send(2'd1, 5, 4);
    send(2'd1, 6, 5);
    send(2'd1, 7, 6);
    fence_wait();
    @(negedge clk);
    peek("R4 flushed line invalid", 1, 0, 0);
    peek("R3 overlapped flush invalid", 6, 0, 0);

    // serialising flush then a flush of a clean hit
    ack_lat = 3;
    send(2'd0, 8, 7);
    send(2'd1, 1, 0);
    fence_wait();
    @(negedge clk);
    peek("R2 serial flush invalid", 7, 0, 0);
    peek("R6 clean hit flush invalidates", 0, 0, 0);

    // miss and clean serial flush
    send(2'd1, 9, 2);
    @(negedge clk);
    peek("R6 miss leaves line", 2, 1, 0);
    send(2'd0, 3, 2);
    @(negedge clk);
    peek("R6 clean serial flush invalidates", 2, 0, 0);

    // stray acknowledge while idle
    force_ack = 1;
    repeat (2) @(posedge clk);
    preload(5, 11, 32'h5555_AAAA, 1, 1);
    send(2'd2, 11, 5);
    @(negedge clk);
    chk("R8 write after stray ack", mem_wr_valid, 1);
    fence_wait();
    @(negedge clk);
    peek("R8 R5 writeback clean", 5, 1, 0);

    // fence with nothing outstanding
    send(2'd3, 0, 0);
    @(negedge clk);
    chk("R9 idle fence done next cycle", fence_done, 1);
    @(negedge clk);
    chk("R9 done single pulse", fence_done, 0);

    repeat (5) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule